// File: doc/BRIEF.md
# Serial ADC Sampling Controller

This block sits on the host side of a three-wire link to a single-channel successive-approximation converter. The link has an active-low select, a serial clock and a serial data return. The controller derives the serial clock from the system clock by an integer divider. It drops the select line to fix the sampling instant and starts the conversion at that same edge. It then clocks sixteen serial-clock cycles, collects the returned bits and presents the result right-aligned on a parallel bus with a one-cycle valid strobe. The converter has no pipeline, so each result belongs to the select edge of its own frame.

Between frames the controller keeps the select line high long enough to meet two rules. The first is a minimum quiet time. The second is a minimum acquisition time measured from the end of conversion, which falls two and a half serial-clock periods before the frame ends. A frame can be requested once with a start pulse. It can also repeat on its own at a programmable period, and that period is never allowed to fall below the shortest legal frame. A request that arrives while a frame or its gap is still running is remembered and served at the first legal moment.

Top module: `serial_adc_ctrl`

## Requirements
- R1: After reset the select and serial clock outputs are high, and both busy and result-valid are low.
- R2: A frame starts on the clock edge after a start request seen while idle. The first serial-clock fall comes SETUP_CYC + SCLK_DIV cycles after the select fall. There are exactly 16 falls, every serial-clock level lasts SCLK_DIV cycles, and the serial clock stays high whenever select is high.
- R3: The data line is sampled at each serial-clock fall, most significant bit first. With res_sel_i = 2'b00 the result is bits 5 to 16 of the frame, and the first four bits have no effect on it.
- R4: With res_sel_i = 2'b01 the result is frame bits 5 to 14; with 2'b10 it is frame bits 5 to 12. Both are right-aligned with zeros above, and the trailing bits have no effect. The code 2'b11 behaves as 2'b00.
- R5: result_vld_o is high for exactly one cycle, the cycle in which select returns high. result_o changes only in that cycle and holds otherwise.
- R6: Between two frames select stays high for at least GAP_CYC = max(QUIET_CYC, ACQ_CYC - 5*SCLK_DIV, 1) cycles, and for exactly GAP_CYC when frames run back to back.
- R7: busy_o rises with the select fall and stays high until the gap has elapsed, which is MIN_FRAME = SETUP_CYC + 32*SCLK_DIV + GAP_CYC cycles for a lone frame.
- R8: A start request made while busy is held, not dropped. Its frame starts exactly MIN_FRAME cycles after the previous select fall.
- R9: With cont_en_i high, frames start every max(period_i, MIN_FRAME) cycles. With cont_en_i low, no frame starts without a request.
- R10: Each result equals the data returned in its own frame, with no carry-over between frames.
- R11: res_sel_i is taken at the select fall; changing it during a frame does not change that frame's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-shot frame request |
| cont_en_i | input | 1 | Enables repeated frames at the programmed period |
| period_i | input | PCNT_W | Frame period in system-clock cycles (raised to MIN_FRAME if lower) |
| res_sel_i | input | 2 | Resolution code: 00 full, 01 full minus RES_STEP, 10 full minus 2*RES_STEP, 11 full |
| adc_sdata_i | input | 1 | Serial data from the converter |
| adc_csn_o | output | 1 | Active-low select; its fall is the sampling instant |
| adc_sclk_o | output | 1 | Serial clock, high when idle |
| result_o | output | RES_W | Last converted sample, right-aligned |
| result_vld_o | output | 1 | One-cycle strobe when a new result is presented |
| busy_o | output | 1 | High from the select fall until the gap has elapsed |

## Verification
The serial return is driven with words whose leading and trailing bits differ from the payload, for example leading ones or trailing ones. This shows whether the controller takes its window at the right place for each resolution code rather than simply taking the last bits shifted in. Back-to-back frames carry different words, which separates a correct per-frame result from one that is stale by a frame. Requests are made both from idle and in the middle of a busy frame, and continuous mode runs with a period below and above the legal minimum. Together these tell apart immediate start, held-off start, clamped repetition and programmed repetition by their exact select-to-select spacing. A resolution code changed in mid-frame checks that the code is taken at the sampling edge.

// File: rtl/adcctl_pkg.sv
package adcctl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_SHIFT = 2'd2,
      ST_GAP   = 2'd3
   } frame_st_e;

   // Resolution codes seen on the select input.
   localparam logic [1:0] RES_CODE_FULL = 2'b00;
   localparam logic [1:0] RES_CODE_ALT  = 2'b11;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adcctl_sclk_gen.sv
module adcctl_sclk_gen #(
   parameter int unsigned HALF_DIV = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic tick,
   output logic fall_now
);

   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end

   if (HALF_DIV == 1) begin : g_div_one
      // Toggle on every system clock while running.
      assign tick = run;
   end else begin : g_div_cnt
      localparam int DW = $clog2(HALF_DIV);
      logic [DW-1:0] divcnt;

      assign tick = run && (divcnt == DW'(HALF_DIV - 1));

      always_ff @(posedge clk) begin
         if (!rst_n || !run || tick) begin
            divcnt <= '0;
         end else begin
            divcnt <= divcnt + 1'b1;
         end
      end
   end

   assign fall_now = tick && sclk;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         sclk <= 1'b1;
      end else if (tick) begin
         sclk <= ~sclk;
      end
   end

endmodule

// File: rtl/adcctl_seq.sv
module adcctl_seq
   import adcctl_pkg::*;
#(
   parameter int SETUP_CYC  = 3,
   parameter int GAP_CYC    = 28,
   parameter int FRAME_CLKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic tick,
   output logic csn,
   output logic busy,
   output logic shift_run,
   output logic sof,
   output logic eof
);

   localparam int TOGGLES = 2 * FRAME_CLKS;
   localparam int CNT_MAX = imax(imax(SETUP_CYC, GAP_CYC), TOGGLES);
   localparam int CW      = $clog2(CNT_MAX + 1);

   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("SETUP_CYC must be at least 1");
   end
   if (GAP_CYC < 1) begin : g_bad_gap
      $error("GAP_CYC must be at least 1");
   end

   frame_st_e     st, nxt;
   logic [CW-1:0] cnt;

   always_comb begin
      nxt = st;
      sof = 1'b0;
      eof = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (go) begin
               nxt = ST_SETUP;
               sof = 1'b1;
            end
         end
         ST_SETUP: begin
            if (cnt == CW'(SETUP_CYC - 1)) nxt = ST_SHIFT;
         end
         ST_SHIFT: begin
            if (tick && cnt == CW'(TOGGLES - 1)) begin
               nxt = ST_GAP;
               eof = 1'b1;
            end
         end
         ST_GAP: begin
            if (cnt == CW'(GAP_CYC - 1)) begin
               if (go) begin
                  nxt = ST_SETUP;
                  sof = 1'b1;
               end else begin
                  nxt = ST_IDLE;
               end
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         cnt  <= '0;
         csn  <= 1'b1;
         busy <= 1'b0;
      end else begin
         st   <= nxt;
         csn  <= !(nxt == ST_SETUP || nxt == ST_SHIFT);
         busy <= (nxt != ST_IDLE);
         if (nxt != st) begin
            cnt <= '0;
         end else if (st == ST_SHIFT) begin
            if (tick) cnt <= cnt + 1'b1;
         end else if (st != ST_IDLE) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign shift_run = (st == ST_SHIFT);

   // Checker: run length of select-high cycles, saturating.
   logic [CW-1:0] hi_run;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_run <= '1;
      end else if (csn) begin
         if (hi_run != '1) hi_run <= hi_run + 1'b1;
      end else begin
         hi_run <= '0;
      end
   end

   AST_CSN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(csn) |-> hi_run >= CW'(GAP_CYC)); // R6
   AST_BUSY_COVERS_CSN: assert property (@(posedge clk) disable iff (!rst_n)
      !csn |-> busy); // R7

endmodule

// File: rtl/adcctl_rx.sv
module adcctl_rx
   import adcctl_pkg::*;
#(
   parameter int RES_W    = 12,
   parameter int RES_STEP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sof,
   input  logic             eof,
   input  logic             capture,
   input  logic             sdata,
   input  logic [1:0]       res_sel,
   output logic [RES_W-1:0] result,
   output logic             result_vld
);

   if (RES_W <= 2 * RES_STEP) begin : g_bad_res
      $error("RES_W must exceed twice RES_STEP");
   end

   // Only the last RES_W bits of a frame are kept; leading bits fall out.
   logic [RES_W-1:0] sreg;
   logic [1:0]       res_q;
   logic [1:0]       sh;

   assign sh = (res_q == RES_CODE_ALT) ? RES_CODE_FULL : res_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sreg       <= '0;
         res_q      <= RES_CODE_FULL;
         result     <= '0;
         result_vld <= 1'b0;
      end else begin
         if (sof) res_q <= res_sel;
         if (capture) sreg <= {sreg[RES_W-2:0], sdata};
         result_vld <= eof;
         if (eof) result <= sreg >> (RES_STEP * int'(sh));
      end
   end

   AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      result_vld |=> !result_vld); // R5
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !result_vld |-> $stable(result)); // R5

endmodule

// File: rtl/adcctl_period.sv
module adcctl_period #(
   parameter int PCNT_W    = 16,
   parameter int MIN_FRAME = 255
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof,
   input  logic              cont_en,
   input  logic [PCNT_W-1:0] period,
   output logic              hit
);

   if (MIN_FRAME >= (2 ** PCNT_W) - 1) begin : g_bad_pw
      $error("PCNT_W too narrow for the minimum frame length");
   end

   logic [PCNT_W-1:0] pcnt;
   logic [PCNT_W-1:0] eff;

   assign eff = (period < PCNT_W'(MIN_FRAME)) ? PCNT_W'(MIN_FRAME) : period;
   assign hit = cont_en && (pcnt >= eff);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pcnt <= '1;
      end else if (sof) begin
         pcnt <= PCNT_W'(1);
      end else if (pcnt != '1) begin
         pcnt <= pcnt + 1'b1;
      end
   end

   AST_PERIOD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      sof |-> pcnt >= PCNT_W'(MIN_FRAME)); // R9

endmodule

// File: rtl/serial_adc_ctrl.sv
module serial_adc_ctrl
   import adcctl_pkg::*;
#(
   parameter int SCLK_DIV   = 7,
   parameter int SETUP_CYC  = 3,
   parameter int QUIET_CYC  = 13,
   parameter int ACQ_CYC    = 63,
   parameter int FRAME_CLKS = 16,
   parameter int RES_W      = 12,
   parameter int RES_STEP   = 2,
   parameter int PCNT_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              cont_en_i,
   input  logic [PCNT_W-1:0] period_i,
   input  logic [1:0]        res_sel_i,
   input  logic              adc_sdata_i,
   output logic              adc_csn_o,
   output logic              adc_sclk_o,
   output logic [RES_W-1:0]  result_o,
   output logic              result_vld_o,
   output logic              busy_o
);

   // End of conversion lies 2.5 serial clocks (5 half periods) before frame end.
   localparam int TAIL_HALVES = 5;
   localparam int ACQ_LEFT    = imax(ACQ_CYC - TAIL_HALVES * SCLK_DIV, 0);
   localparam int GAP_CYC     = imax(imax(QUIET_CYC, ACQ_LEFT), 1);
   localparam int MIN_FRAME   = SETUP_CYC + 2 * FRAME_CLKS * SCLK_DIV + GAP_CYC;

   if (FRAME_CLKS < RES_W) begin : g_bad_frame
      $error("FRAME_CLKS must cover RES_W");
   end

   logic tick, fall_now, shift_run, sof, eof, hit, go, req_pend;

   assign go = start_i || req_pend || hit;

   always_ff @(posedge clk) begin
      if (!rst_n) req_pend <= 1'b0;
      else        req_pend <= (req_pend || start_i) && !sof;
   end

   adcctl_sclk_gen #(.HALF_DIV(SCLK_DIV)) u_sclk (
      .clk(clk), .rst_n(rst_n), .run(shift_run),
      .sclk(adc_sclk_o), .tick(tick), .fall_now(fall_now)
   );

   adcctl_seq #(
      .SETUP_CYC(SETUP_CYC), .GAP_CYC(GAP_CYC), .FRAME_CLKS(FRAME_CLKS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .tick(tick),
      .csn(adc_csn_o), .busy(busy_o), .shift_run(shift_run),
      .sof(sof), .eof(eof)
   );

   adcctl_rx #(.RES_W(RES_W), .RES_STEP(RES_STEP)) u_rx (
      .clk(clk), .rst_n(rst_n), .sof(sof), .eof(eof),
      .capture(fall_now), .sdata(adc_sdata_i), .res_sel(res_sel_i),
      .result(result_o), .result_vld(result_vld_o)
   );

   adcctl_period #(.PCNT_W(PCNT_W), .MIN_FRAME(MIN_FRAME)) u_period (
      .clk(clk), .rst_n(rst_n), .sof(sof), .cont_en(cont_en_i),
      .period(period_i), .hit(hit)
   );

   AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      adc_csn_o |-> adc_sclk_o); // R2
   AST_VLD_AT_CSN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      result_vld_o |-> $rose(adc_csn_o)); // R5
   AST_HELD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_o && !sof) |=> req_pend); // R8

endmodule

// File: tb/serial_adc_ctrl_bench.sv
`timescale 1ns/1ps
module serial_adc_ctrl_bench;

   localparam int DIV   = 7;
   localparam int SETUP = 3;
   localparam int QUIET = 13;
   localparam int ACQ   = 63;
   localparam int GAPC  = (QUIET > ACQ - 5 * DIV) ? QUIET : ACQ - 5 * DIV;
   localparam int MINF  = SETUP + 32 * DIV + GAPC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        cont_en = 1'b0;
   logic [15:0] period = 16'd0;
   logic [1:0]  res_sel = 2'b00;
   logic        adc_sdata = 1'b0;
   logic        adc_csn_o, adc_sclk_o, result_vld_o, busy_o;
   logic [11:0] result_o;

   always #2 clk = ~clk;

   serial_adc_ctrl u_serial_adc_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start), .cont_en_i(cont_en),
      .period_i(period), .res_sel_i(res_sel), .adc_sdata_i(adc_sdata),
      .adc_csn_o(adc_csn_o), .adc_sclk_o(adc_sclk_o), .result_o(result_o),
      .result_vld_o(result_vld_o), .busy_o(busy_o)
   );

   int n_chk = 0, n_fail = 0;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Converter model: first bit at select fall, next bit after each clock fall.
   logic [15:0] tx_word = 16'h0;
   int          bit_i = 0;
   always @(negedge adc_csn_o) begin
      bit_i = 0;
      adc_sdata = tx_word[15];
   end
   always @(negedge adc_sclk_o) begin
      if (!adc_csn_o) begin
         #1;
         bit_i++;
         adc_sdata = (bit_i < 16) ? tx_word[15 - bit_i] : 1'b0;
      end
   end

   // Observation of the ports, sampled away from the active edge.
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int t_fall = 0, t_fall_prev = 0, t_rise = 0, hi_gap = 0, lo_len = 0;
   int first_fall = 0, nfall = 0, last_tog = 0, tog_min = 0, tog_max = 0;
   int t_busy = 0, busy_len = 0, vld_cnt = 0, t_vld = 0, vld_run = 0, vld_run_max = 0;
   int frames = 0, last_res = 0;
   bit seen_rise = 1'b0;
   logic p_csn = 1'b1, p_sclk = 1'b1, p_busy = 1'b0;

   always @(negedge clk) begin
      if (p_csn && !adc_csn_o) begin
         if (seen_rise) hi_gap = cyc - t_rise;
         t_fall_prev = t_fall;
         t_fall = cyc;
         nfall = 0; tog_min = 1000000; tog_max = 0; last_tog = cyc;
         frames++;
      end
      if (!p_csn && adc_csn_o) begin
         t_rise = cyc; seen_rise = 1'b1; lo_len = cyc - t_fall;
      end
      if (!p_csn && adc_sclk_o != p_sclk) begin
         if (!adc_sclk_o && nfall == 0) begin
            first_fall = cyc - t_fall;
         end else begin
            if (cyc - last_tog < tog_min) tog_min = cyc - last_tog;
            if (cyc - last_tog > tog_max) tog_max = cyc - last_tog;
         end
         if (!adc_sclk_o) nfall++;
         last_tog = cyc;
      end
      if (!p_busy && busy_o) t_busy = cyc;
      if (p_busy && !busy_o) busy_len = cyc - t_busy;
      if (result_vld_o) begin
         vld_cnt++; t_vld = cyc; last_res = int'(result_o);
         vld_run++;
         if (vld_run > vld_run_max) vld_run_max = vld_run;
      end else begin
         vld_run = 0;
      end
      p_csn = adc_csn_o; p_sclk = adc_sclk_o; p_busy = busy_o;
   end

   task automatic wait_vld();
      int n = vld_cnt;
      while (vld_cnt == n) @(negedge clk);
   endtask

   task automatic wait_idle();
      while (busy_o) @(negedge clk);
      @(negedge clk);
   endtask

   int t_req = 0;

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1; t_req = cyc;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic one_shot(input logic [1:0] sel, input logic [15:0] tx);
      @(negedge clk);
      res_sel = sel; tx_word = tx;
      pulse_start();
      wait_vld();
      wait_idle();
   endtask

   task automatic t_reset();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 csn", int'(adc_csn_o), 1);
      chk("R1 sclk", int'(adc_sclk_o), 1);
      chk("R1 busy", int'(busy_o), 0);
      chk("R1 vld", int'(result_vld_o), 0);
   endtask

   task automatic t_basic();
      one_shot(2'b00, 16'hFABC);
      chk("R2 start latency", t_fall - t_req, 1);
      chk("R2 first fall", first_fall, SETUP + DIV);
      chk("R2 fall count", nfall, 16);
      chk("R2 min level", tog_min, DIV);
      chk("R2 max level", tog_max, DIV);
      chk("R3 result 12b leading ignored", last_res, 12'hABC);
      chk("R5 vld at csn rise", t_vld, t_rise);
      chk("R5 vld width", vld_run_max, 1);
      chk("R7 select low time", lo_len, SETUP + 32 * DIV);
      chk("R7 busy time", busy_len, MINF);
      chk("R5 result held", int'(result_o), 12'hABC);
   endtask

   task automatic t_modes();
      one_shot(2'b01, {4'h0, 10'h3C5, 2'b11});
      chk("R4 10-bit", last_res, 10'h3C5);
      one_shot(2'b10, {4'h0, 8'h96, 4'hF});
      chk("R4 8-bit", last_res, 8'h96);
      one_shot(2'b11, {4'h0, 12'h5A3});
      chk("R4 code 11 as full", last_res, 12'h5A3);
   endtask

   task automatic t_holdoff();
      @(negedge clk);
      res_sel = 2'b00; tx_word = 16'h0123;
      pulse_start();
      repeat (20) @(negedge clk);
      chk("R8 busy at second request", int'(busy_o), 1);
      pulse_start();
      wait_vld();
      chk("R10 first result", last_res, 12'h123);
      tx_word = 16'h0E5D;
      wait_vld();
      chk("R10 second result", last_res, 12'hE5D);
      chk("R8 held start spacing", t_fall - t_fall_prev, MINF);
      chk("R6 back-to-back gap", hi_gap, GAPC);
      wait_idle();
   endtask

   task automatic t_latch();
      @(negedge clk);
      res_sel = 2'b01; tx_word = {4'h0, 10'h2A5, 2'b10};
      pulse_start();
      repeat (10) @(negedge clk);
      res_sel = 2'b10;
      wait_vld();
      chk("R11 code taken at select fall", last_res, 10'h2A5);
      wait_idle();
   endtask

   task automatic t_continuous();
      int f0;
      @(negedge clk);
      res_sel = 2'b00; tx_word = 16'h0777; period = 16'd10; cont_en = 1'b1;
      repeat (3) wait_vld();
      chk("R9 clamped period", t_fall - t_fall_prev, MINF);
      chk("R6 gap in clamped run", hi_gap, GAPC);
      chk("R9 result in run", last_res, 12'h777);
      period = 16'd400;
      repeat (3) wait_vld();
      chk("R9 programmed period", t_fall - t_fall_prev, 400);
      cont_en = 1'b0;
      wait_idle();
      f0 = frames;
      repeat (600) @(negedge clk);
      chk("R9 stops when disabled", frames, f0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_basic();
      t_modes();
      t_holdoff();
      t_latch();
      t_continuous();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule